// File: doc/BRIEF.md
# Host Parallel Bus Port for a Character Display Controller

This block is the host-facing slave of a character display controller. A host processor drives a register-select line, a read/not-write line, an enable strobe and a byte-wide data bus. The port samples those lines, works out which access is meant, and hands the core one-cycle write strobes with the assembled byte, or puts the core's read value on the bus. A write with register-select low goes to the instruction register. A write with it high goes to the data register. A read with register-select low returns a status byte: the busy flag on bit 7 and the address counter below it. A read with it high returns the byte the core has prefetched, and then asks the core to step its address counter.

The bus can run a full byte per strobe, or in a narrow mode chosen by the core at run time. In narrow mode only the upper four lines carry data and each byte takes two strobes, upper half first. All inputs are taken as already synchronous to the internal clock. The data bus is split into an input vector, an output vector and an output enable, so a pad ring can build the three-state buffer from them.

Top module: `hostBusPort`

## Requirements
- R1: After reset, all strobes, the address-advance pulse and the bus enable are 0, and the first transfer in narrow mode is taken as the upper half.
- R2: A wide-mode write with selReg=0 gives instWrStb=1 for exactly one cycle, with wrByte equal to the bus byte, in the cycle after the first clock edge that sees strobe low.
- R3: A wide-mode write with selReg=1 gives dataWrStb for one cycle with the bus byte, timed as in R2. It never gives instWrStb.
- R4: busOe is 1 only while strobe=1 and rdNotWr=1. While busOe is 0, busOut is 0.
- R5: A read with selReg=0 drives {busyFlag, addrCnt[6:0]}, with the busy flag on bit 7. It gives no address-advance pulse.
- R6: A read with selReg=1 drives rdData while strobe is high. advanceAddr then pulses for one cycle, timed as in R2.
- R7: In narrow mode, a write takes bits 7:4 of two strobes, upper half first. Bits 3:0 are ignored. No write strobe follows the first strobe, and exactly one follows the second, carrying the joined byte.
- R8: In narrow mode, the first read strobe drives the upper half of the value on bits 7:4, and the second drives the lower half there. Bits 3:0 read 0. advanceAddr pulses only after the second strobe.
- R9: Dropping narrowMode to 0 discards a half-finished byte. The next narrow transfer is again the upper half, and wide-mode writes complete on a single strobe.
- R10: instWrStb and dataWrStb are never high together. Neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | internal clock |
| rstN | input | 1 | active-low reset |
| selReg | input | 1 | 0: instruction/status, 1: data register |
| rdNotWr | input | 1 | 1 read, 0 write |
| strobe | input | 1 | host enable strobe |
| busIn | input | 8 | data bus as seen from the host |
| busOut | output | 8 | value driven onto the bus during reads |
| busOe | output | 1 | enable for the bus drivers |
| narrowMode | input | 1 | 1: four-bit transfers on bits 7:4 |
| busyFlag | input | 1 | core busy indication |
| addrCnt | input | 7 | core address counter |
| rdData | input | 8 | core prefetched read byte |
| instWrStb | output | 1 | instruction register write pulse |
| dataWrStb | output | 1 | data register write pulse |
| wrByte | output | 8 | byte belonging to the write pulse |
| advanceAddr | output | 1 | read-complete pulse to step the address counter |

## Verification
Read values are combinational: busOe and busOut follow strobe, rdNotWr and the half-select in the same cycle, so the bench samples them one cycle into a high strobe. The write strobes, wrByte and advanceAddr come through one register placed after the falling-edge detect. They are due in the cycle after the first clock edge that sees strobe low. The bench samples them at the falling clock edge inside that cycle, and samples again one cycle later to confirm that the pulse has ended. Narrow-mode checks sample after each of the two strobes.

// File: rtl/hostBusPkg.sv
package hostBusPkg;
  localparam int BUS_W = 8;

  typedef struct packed {
    logic driveBus;
    logic captureHi;
    logic writeInst;
    logic writeData;
    logic advance;
  } busStb_t;
endpackage

// File: rtl/hostBusCtrl.sv
module hostBusCtrl
  import hostBusPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    strobe,
  input  logic    selReg,
  input  logic    rdNotWr,
  input  logic    narrowMode,
  output busStb_t stb,
  output logic    lowHalf
);
  logic enPrev;
  logic enFall;
  logic lastPart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev  <= 1'b0;
      lowHalf <= 1'b0;
    end else begin
      enPrev <= strobe;
      if (!narrowMode)
        lowHalf <= 1'b0;
      else if (enFall)
        lowHalf <= ~lowHalf;
    end
  end

  assign enFall   = enPrev & ~strobe;
  assign lastPart = ~narrowMode | lowHalf;

  always_comb begin
    stb.driveBus  = strobe & rdNotWr;
    stb.captureHi = enFall & narrowMode & ~lowHalf & ~rdNotWr;
    stb.writeInst = enFall & lastPart & ~rdNotWr & ~selReg;
    stb.writeData = enFall & lastPart & ~rdNotWr & selReg;
    stb.advance   = enFall & lastPart & rdNotWr & selReg;
  end
endmodule

// File: rtl/hostBusPath.sv
module hostBusPath
  import hostBusPkg::*;
#(
  parameter int DATA_W = BUS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStb_t           stb,
  input  logic              lowHalf,
  input  logic              narrowMode,
  input  logic              selReg,
  input  logic [DATA_W-1:0] busIn,
  input  logic              busyFlag,
  input  logic [DATA_W-2:0] addrCnt,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic              instWrStb,
  output logic              dataWrStb,
  output logic [DATA_W-1:0] wrByte,
  output logic              advanceAddr
);
  localparam int HALF = DATA_W / 2;

  logic [HALF-1:0]   hiNib;
  logic [DATA_W-1:0] readVal;
  logic [DATA_W-1:0] joined;

  assign joined = narrowMode ? {hiNib, busIn[DATA_W-1:HALF]} : busIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiNib       <= '0;
      instWrStb   <= 1'b0;
      dataWrStb   <= 1'b0;
      advanceAddr <= 1'b0;
      wrByte      <= '0;
    end else begin
      instWrStb   <= stb.writeInst;
      dataWrStb   <= stb.writeData;
      advanceAddr <= stb.advance;
      if (stb.captureHi)
        hiNib <= busIn[DATA_W-1:HALF];
      if (stb.writeInst || stb.writeData)
        wrByte <= joined;
    end
  end

  assign readVal = selReg ? rdData : {busyFlag, addrCnt};
  assign busOe   = stb.driveBus;

  always_comb begin
    if (!stb.driveBus)
      busOut = '0;
    else if (!narrowMode)
      busOut = readVal;
    else if (!lowHalf)
      busOut = {readVal[DATA_W-1:HALF], {HALF{1'b0}}};
    else
      busOut = {readVal[HALF-1:0], {HALF{1'b0}}};
  end
endmodule

// File: rtl/hostBusPort.sv
module hostBusPort
  import hostBusPkg::*;
#(
  parameter int DATA_W = BUS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selReg,
  input  logic              rdNotWr,
  input  logic              strobe,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  input  logic              narrowMode,
  input  logic              busyFlag,
  input  logic [DATA_W-2:0] addrCnt,
  input  logic [DATA_W-1:0] rdData,
  output logic              instWrStb,
  output logic              dataWrStb,
  output logic [DATA_W-1:0] wrByte,
  output logic              advanceAddr
);
  busStb_t stb;
  logic    lowHalf;

  hostBusCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selReg(selReg),
    .rdNotWr(rdNotWr), .narrowMode(narrowMode), .stb(stb), .lowHalf(lowHalf)
  );

  hostBusPath #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .lowHalf(lowHalf),
    .narrowMode(narrowMode), .selReg(selReg), .busIn(busIn),
    .busyFlag(busyFlag), .addrCnt(addrCnt), .rdData(rdData),
    .busOut(busOut), .busOe(busOe), .instWrStb(instWrStb),
    .dataWrStb(dataWrStb), .wrByte(wrByte), .advanceAddr(advanceAddr)
  );
endmodule

// File: rtl/hostBusPortChk.sv
module hostBusPortChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              selReg,
  input logic              rdNotWr,
  input logic              strobe,
  input logic [DATA_W-1:0] busOut,
  input logic              busOe,
  input logic              narrowMode,
  input logic              busyFlag,
  input logic              instWrStb,
  input logic              dataWrStb,
  input logic              advanceAddr
);
  // R4: drivers only during a read strobe
  p_oe_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe |-> (!busOe && busOut == '0));

  // R5: busy flag on the top bit of a wide status read
  p_busy_top_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && !selReg && !narrowMode) |-> busOut[DATA_W-1] == busyFlag);

  // R6: an address step only follows a data read
  p_adv_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    advanceAddr |-> ($past(selReg) && $past(rdNotWr) && !$past(strobe)));

  // R3: write pulses only follow a write strobe that has ended
  p_wr_dir_r3: assert property (@(posedge clk) disable iff (!rstN)
    (instWrStb || dataWrStb) |-> (!$past(rdNotWr) && !$past(strobe)));

  // R8: lower lines read zero in narrow mode
  p_nib_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && narrowMode) |-> busOut[DATA_W/2-1:0] == '0);

  // R10: exclusive, single-cycle pulses
  p_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(instWrStb && dataWrStb));
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    (instWrStb || dataWrStb) |=> !(instWrStb || dataWrStb));
endmodule

bind hostBusPort hostBusPortChk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .selReg(selReg), .rdNotWr(rdNotWr),
  .strobe(strobe), .busOut(busOut), .busOe(busOe),
  .narrowMode(narrowMode), .busyFlag(busyFlag), .instWrStb(instWrStb),
  .dataWrStb(dataWrStb), .advanceAddr(advanceAddr)
);

// File: tb/hostBusPort_tb.sv
module hostBusPort_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selReg = 1'b0, rdNotWr = 1'b0, strobe = 1'b0, narrowMode = 1'b0;
  logic [7:0] busIn = '0;
  logic busyFlag = 1'b1;
  logic [6:0] addrCnt = 7'h2A;
  logic [7:0] rdData = 8'hC3;
  logic [7:0] busOut, wrByte;
  logic busOe, instWrStb, dataWrStb, advanceAddr;

  int total = 0;
  int bad = 0;

  logic [7:0] gotOut, gotByte;
  logic gotOe, gotInst, gotData, gotAdv, afterAny, idleOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostBusPort u_dut (
    .clk(clk), .rstN(rstN), .selReg(selReg), .rdNotWr(rdNotWr),
    .strobe(strobe), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .narrowMode(narrowMode), .busyFlag(busyFlag), .addrCnt(addrCnt),
    .rdData(rdData), .instWrStb(instWrStb), .dataWrStb(dataWrStb),
    .wrByte(wrByte), .advanceAddr(advanceAddr)
  );

  // {rs, rw, bus, expInst, expData, expAdv, expByteOrRead}
  localparam logic [20:0] VECS [6] = '{
    {1'b0, 1'b0, 8'h38, 1'b1, 1'b0, 1'b0, 8'h38},
    {1'b1, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, 8'hA5},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'hAA},
    {1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'hC3},
    {1'b0, 1'b0, 8'h01, 1'b1, 1'b0, 1'b0, 8'h01},
    {1'b1, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0, 8'hFF}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic r, input logic w, input logic [7:0] d);
    @(negedge clk);
    selReg = r; rdNotWr = w; busIn = d; strobe = 1'b1;
    @(negedge clk);
    gotOe = busOe; gotOut = busOut;
    @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
    gotInst = instWrStb; gotData = dataWrStb; gotAdv = advanceAddr; gotByte = wrByte;
    @(negedge clk);
    afterAny = instWrStb | dataWrStb | advanceAddr;
    idleOe = busOe | (busOut != 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 strobes at reset", {instWrStb, dataWrStb, advanceAddr, busOe}, 8'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", {instWrStb, dataWrStb, advanceAddr, busOe}, 8'h0);

    foreach (VECS[i]) begin
      logic [20:0] v;
      string tag;
      v = VECS[i];
      if (!v[19]) tag = v[20] ? "R3 data write" : "R2 instruction write";
      else        tag = v[20] ? "R6 data read" : "R5 status read";
      xfer(v[20], v[19], v[18:11]);
      check(tag, {gotInst, gotData, gotAdv}, v[10:8]);
      if (v[19]) begin
        check(tag, gotOut, v[7:0]);
        check("R4 enable during read", gotOe, 1'b1);
      end else begin
        check(tag, gotByte, v[7:0]);
        check("R4 no enable during write", gotOe, 1'b0);
      end
      check("R10 pulse ends", afterAny, 1'b0);
      check("R4 idle bus", idleOe, 1'b0);
    end

    // R7: narrow write, upper half first, lower lines ignored
    narrowMode = 1'b1;
    xfer(1'b0, 1'b0, 8'h2F);
    check("R7 no strobe after first half", {gotInst, gotData}, 8'h0);
    xfer(1'b0, 1'b0, 8'h8C);
    check("R7 one strobe after second half", {gotInst, gotData}, 8'h2);
    check("R7 joined byte", gotByte, 8'h28);
    xfer(1'b1, 1'b0, 8'h93);
    xfer(1'b1, 1'b0, 8'h4E);
    check("R7 data joined byte", gotByte, 8'h94);
    check("R7 data strobe", {gotInst, gotData}, 8'h1);

    // R8: narrow read, halves on the upper lines
    xfer(1'b1, 1'b1, 8'h00);
    check("R8 upper half", gotOut, 8'hC0);
    check("R8 no step after first", gotAdv, 1'b0);
    xfer(1'b1, 1'b1, 8'h00);
    check("R8 lower half", gotOut, 8'h30);
    check("R8 step after second", gotAdv, 1'b1);
    xfer(1'b0, 1'b1, 8'h00);
    check("R8 status upper", gotOut, 8'hA0);
    xfer(1'b0, 1'b1, 8'h00);
    check("R8 status lower", gotOut, 8'hA0);
    check("R5 status no step", gotAdv, 1'b0);

    // R9: leaving narrow mode discards the pending half
    xfer(1'b0, 1'b0, 8'h50);
    @(negedge clk);
    narrowMode = 1'b0;
    xfer(1'b0, 1'b0, 8'h99);
    check("R9 wide write after drop", gotByte, 8'h99);
    check("R9 wide strobe", gotInst, 1'b1);
    narrowMode = 1'b1;
    xfer(1'b0, 1'b0, 8'h70);
    check("R9 restart at upper half", {gotInst, gotData}, 8'h0);
    xfer(1'b0, 1'b0, 8'h10);
    check("R9 restarted byte", gotByte, 8'h71);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule